// File: doc/BRIEF.md
# Compressed Page Line Locator

This block sits on the read path of a memory controller that keeps pages in compressed form. Every page has one of four size classes, and every cache line of the page owns a compressed slot of the same fixed size. The block takes one request at a time: the page base, the size class, the slot size in bytes, the 6-bit line number and the identifier of the page's compression algorithm. It answers with the address the line must be fetched from, plus a flag that tells whether the data still has to be decompressed.

The line's position follows from plain arithmetic. The metadata word sits right after the 64 compressed slots. It is followed by up to eight 64-byte overflow slots that hold lines which did not fit their compressed slot. When the page has room for at least one overflow slot, the block reads the metadata word through a one-cycle-latency read port. It then searches the metadata for a valid overflow entry that names the requested line. A hit returns the overflow slot address, flagged as uncompressed. A miss returns the compressed slot address together with the algorithm identifier. A request whose 64 slots do not fit in the page gets an error response.

Top module: `cpl_line_locator`

## Requirements
- R1: While reset is held, `req_ready` is 1, and `resp_valid` and `meta_rd_en` are 0.
- R2: Size class code 0, 1, 2 and 3 selects a page of 512, 1024, 2048 and 4096 bytes.
- R3: When no overflow entry matches, the response address is base + line × slot_bytes (modulo 2^40), `resp_compressed` is 1 and `resp_alg` echoes the request's algorithm identifier.
- R4: The metadata address is base + 64 × slot_bytes. Each accepted request that has at least one overflow slot issues exactly one read there, for one cycle, and the response becomes valid two cycles after the read cycle.
- R5: The number of usable overflow slots is floor((page − 64 × slot_bytes − 8) / 64), taken as 0 when negative and capped at 8. Valid bits of slots at or above that count are ignored.
- R6: A line hits overflow slot k when bit k of the metadata word is 1 and its 6-bit entry equals the line number. A hit answers base + 64 × slot_bytes + 8 + 64 × k, with `resp_compressed` 0 and `resp_alg` 0.
- R7: When several usable overflow slots match, the lowest-numbered one is returned.
- R8: In the 56-bit metadata word, bits [7:0] are the valid bits of slots 0..7, and the entry of slot k occupies bits [8+6k +: 6].
- R9: If 64 × slot_bytes is larger than the page, the response has `resp_err` 1, address 0, `resp_compressed` 0 and `resp_alg` 0, and no metadata read takes place.
- R10: A request that fits but leaves no room for an overflow slot issues no metadata read and is answered as compressed one cycle after acceptance.
- R11: Only one request is in flight. `req_ready` is low from acceptance until the response handshake, and a response held back by `resp_ready` keeps its values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_base | input | 40 | Page base address |
| req_cls | input | 2 | Page size class code |
| req_slot_b | input | 7 | Compressed slot size in bytes |
| req_idx | input | 6 | Line number within the page |
| req_alg | input | 3 | Compression algorithm identifier |
| meta_rd_en | output | 1 | Metadata read strobe |
| meta_rd_addr | output | 40 | Metadata address |
| meta_rd_data | input | 56 | Metadata word, valid the cycle after the strobe |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_addr | output | 40 | Address to fetch the line from |
| resp_compressed | output | 1 | Line must be decompressed |
| resp_alg | output | 3 | Algorithm for decompression, 0 otherwise |
| resp_err | output | 1 | Slots do not fit in the page |

## Verification
The bench sweeps all four size classes against slot sizes on both sides of each overflow-count boundary. That separates the error case, the zero-slot case that skips the metadata read, partly filled overflow areas and the capped case. For each geometry, several metadata patterns are tried against several line numbers. Valid slots with non-matching entries and matching entries with cleared valid bits tell the two halves of the hit test apart. A lone match in slot 7 hits only when eight slots exist. Multiple matches expose the priority order. Response backpressure of varying length, and a base near the top of the address space, cover the hold behaviour and address wrap.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_RESP
  } cpl_state_e;

  // Page size in bytes for a size class code.
  function automatic int unsigned cpl_page_bytes(input logic [1:0] cls,
                                                 input int unsigned smallest);
    return smallest << cls;
  endfunction

  // Usable overflow slots once data slots and the metadata word are placed.
  function automatic int unsigned cpl_ovf_slots(input int unsigned page_b,
                                                input int unsigned data_b,
                                                input int unsigned meta_b,
                                                input int unsigned line_sh,
                                                input int unsigned cap);
    int unsigned room;
    if (data_b + meta_b > page_b) return 0;
    room = (page_b - data_b - meta_b) >> line_sh;
    return (room > cap) ? cap : room;
  endfunction

endpackage

// File: rtl/cpl_geom.sv
module cpl_geom
  import cpl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned SLOT_W     = 7,
  parameter int unsigned MIN_PAGE_B = 512,
  parameter int unsigned LINE_SH    = 6,
  parameter int unsigned META_B     = 8,
  parameter int unsigned MAX_OVF    = 8,
  parameter int unsigned CNT_W      = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        cls_i,
  input  logic [SLOT_W-1:0] slot_b_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [ADDR_W-1:0] meta_addr_o,
  output logic [ADDR_W-1:0] ovf_base_o,
  output logic [CNT_W-1:0]  ovf_cnt_o,
  output logic              too_big_o
);
  localparam int unsigned LINES = 1 << IDX_W;

  int unsigned page_b;
  int unsigned data_b;

  always_comb begin
    page_b      = cpl_page_bytes(cls_i, MIN_PAGE_B);
    data_b      = 32'(slot_b_i) * LINES;
    too_big_o   = data_b > page_b;
    ovf_cnt_o   = CNT_W'(cpl_ovf_slots(page_b, data_b, META_B, LINE_SH, MAX_OVF));
    line_addr_o = base_i + ADDR_W'(idx_i) * ADDR_W'(slot_b_i);
    meta_addr_o = base_i + ADDR_W'(data_b);
    ovf_base_o  = meta_addr_o + ADDR_W'(META_B);
  end

endmodule

// File: rtl/cpl_ovf_match.sv
module cpl_ovf_match #(
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned MAX_OVF = 8,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned META_W  = MAX_OVF * (IDX_W + 1)
) (
  input  logic [META_W-1:0] meta_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic [MAX_OVF-1:0] cand;

  for (genvar k = 0; k < MAX_OVF; k++) begin : g_slot
    assign cand[k] = meta_i[k]
                   && (meta_i[MAX_OVF + k*IDX_W +: IDX_W] == idx_i)
                   && (CNT_W'(k) < cnt_i);
  end

  always_comb begin
    hit_o = |cand;
    sel_o = '0;
    for (int k = MAX_OVF - 1; k >= 0; k--) begin
      if (cand[k]) sel_o = SEL_W'(k);
    end
  end

endmodule

// File: rtl/cpl_line_locator.sv
module cpl_line_locator
  import cpl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned SLOT_W     = 7,
  parameter int unsigned ALG_W      = 3,
  parameter int unsigned MAX_OVF    = 8,
  parameter int unsigned MIN_PAGE_B = 512,
  parameter int unsigned LINE_SH    = 6,
  parameter int unsigned META_B     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [1:0]        req_cls,
  input  logic [SLOT_W-1:0] req_slot_b,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ALG_W-1:0]  req_alg,
  output logic              meta_rd_en,
  output logic [ADDR_W-1:0] meta_rd_addr,
  input  logic [MAX_OVF*(IDX_W+1)-1:0] meta_rd_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              resp_compressed,
  output logic [ALG_W-1:0]  resp_alg,
  output logic              resp_err
);
  localparam int unsigned CNT_W  = $clog2(MAX_OVF + 1);
  localparam int unsigned SEL_W  = (MAX_OVF > 1) ? $clog2(MAX_OVF) : 1;
  localparam int unsigned META_W = MAX_OVF * (IDX_W + 1);

  cpl_state_e state_q;

  // Geometry of the incoming request
  logic [ADDR_W-1:0] g_line, g_meta, g_ovfb;
  logic [CNT_W-1:0]  g_cnt;
  logic              g_err;

  // Latched request
  logic [IDX_W-1:0]  idx_q;
  logic [ALG_W-1:0]  alg_q;
  logic [ADDR_W-1:0] line_q, meta_q, ovfb_q;
  logic [CNT_W-1:0]  cnt_q;

  // Response registers
  logic [ADDR_W-1:0] raddr_q;
  logic              rcmp_q, rerr_q;
  logic [ALG_W-1:0]  ralg_q;

  // Named internal events for the assertions
  logic              accept;
  logic              mt_eval;
  logic              mt_hit;
  logic [SEL_W-1:0]  mt_sel;

  cpl_geom #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .MIN_PAGE_B(MIN_PAGE_B),
    .LINE_SH(LINE_SH), .META_B(META_B), .MAX_OVF(MAX_OVF), .CNT_W(CNT_W)
  ) geom_i (
    .base_i(req_base), .cls_i(req_cls), .slot_b_i(req_slot_b), .idx_i(req_idx),
    .line_addr_o(g_line), .meta_addr_o(g_meta), .ovf_base_o(g_ovfb),
    .ovf_cnt_o(g_cnt), .too_big_o(g_err)
  );

  cpl_ovf_match #(
    .IDX_W(IDX_W), .MAX_OVF(MAX_OVF), .CNT_W(CNT_W), .SEL_W(SEL_W), .META_W(META_W)
  ) match_i (
    .meta_i(meta_rd_data), .cnt_i(cnt_q), .idx_i(idx_q),
    .hit_o(mt_hit), .sel_o(mt_sel)
  );

  assign req_ready       = (state_q == ST_IDLE);
  assign accept          = req_valid && req_ready;
  assign mt_eval         = (state_q == ST_WAIT);
  assign meta_rd_en      = (state_q == ST_READ);
  assign meta_rd_addr    = meta_q;
  assign resp_valid      = (state_q == ST_RESP);
  assign resp_addr       = raddr_q;
  assign resp_compressed = rcmp_q;
  assign resp_alg        = ralg_q;
  assign resp_err        = rerr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      alg_q   <= '0;
      line_q  <= '0;
      meta_q  <= '0;
      ovfb_q  <= '0;
      cnt_q   <= '0;
      raddr_q <= '0;
      rcmp_q  <= 1'b0;
      rerr_q  <= 1'b0;
      ralg_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          idx_q  <= req_idx;
          alg_q  <= req_alg;
          line_q <= g_line;
          meta_q <= g_meta;
          ovfb_q <= g_ovfb;
          cnt_q  <= g_cnt;
          if (g_err) begin
            raddr_q <= '0;
            rcmp_q  <= 1'b0;
            ralg_q  <= '0;
            rerr_q  <= 1'b1;
            state_q <= ST_RESP;
          end else if (g_cnt == '0) begin
            raddr_q <= g_line;
            rcmp_q  <= 1'b1;
            ralg_q  <= req_alg;
            rerr_q  <= 1'b0;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_WAIT;
        ST_WAIT: begin
          rerr_q <= 1'b0;
          if (mt_hit) begin
            raddr_q <= ovfb_q + (ADDR_W'(mt_sel) << LINE_SH);
            rcmp_q  <= 1'b0;
            ralg_q  <= '0;
          end else begin
            raddr_q <= line_q;
            rcmp_q  <= 1'b1;
            ralg_q  <= alg_q;
          end
          state_q <= ST_RESP;
        end
        ST_RESP: if (resp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11: a stalled response keeps its contents
  p_hold_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_addr)
      && $stable(resp_compressed) && $stable(resp_err) && $stable(resp_alg));

  // R4: the metadata strobe lasts one cycle and is answered two cycles later
  p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meta_rd_en |=> !meta_rd_en);
  p_read_to_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meta_rd_en |=> ##1 resp_valid);

  // R5: overflow count is capped, and a hit never lands beyond the count
  p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> g_cnt <= CNT_W'(MAX_OVF));
  p_hit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mt_eval && mt_hit |-> CNT_W'(mt_sel) < cnt_q);

  // R6: uncompressed responses carry no algorithm
  p_uncmp_alg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_compressed |-> resp_alg == '0);

  // R9: error responses are clean
  p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_err |-> !resp_compressed && resp_addr == '0);

endmodule

// File: tb/cpl_line_locator_tb_top.sv
module cpl_line_locator_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_base = '0;
  logic [1:0]  req_cls = '0;
  logic [6:0]  req_slot_b = '0;
  logic [5:0]  req_idx = '0;
  logic [2:0]  req_alg = '0;
  logic        meta_rd_en;
  logic [39:0] meta_rd_addr;
  logic [55:0] meta_rd_data = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [39:0] resp_addr;
  logic        resp_compressed;
  logic [2:0]  resp_alg;
  logic        resp_err;

  int          n_run = 0;
  int          n_fail = 0;
  int          rd_cnt = 0;
  logic [39:0] rd_addr = '0;
  logic [55:0] tb_meta = '0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cpl_line_locator dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_cls(req_cls), .req_slot_b(req_slot_b),
    .req_idx(req_idx), .req_alg(req_alg),
    .meta_rd_en(meta_rd_en), .meta_rd_addr(meta_rd_addr), .meta_rd_data(meta_rd_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_addr(resp_addr),
    .resp_compressed(resp_compressed), .resp_alg(resp_alg), .resp_err(resp_err)
  );

  // Metadata memory with one cycle of latency
  always @(posedge clk) begin
    if (meta_rd_en) begin
      meta_rd_data <= tb_meta;
      rd_cnt       <= rd_cnt + 1;
      rd_addr      <= meta_rd_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Metadata word: valid bits [7:0], entry k at [8+6k +: 6] (R8)
  function automatic logic [55:0] mk_meta(input int pat, input logic [5:0] idx);
    logic [55:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      case (pat)
        1: begin w[k] = 1'b1; w[8+6*k +: 6] = idx + 6'(k + 1); end
        2: begin w[k] = 1'b1; w[8+6*k +: 6] = idx; end
        3: if (k == 7) begin w[k] = 1'b1; w[8+6*k +: 6] = idx; end
        4: begin
             if (k == 3 || k == 5) begin w[k] = 1'b1; w[8+6*k +: 6] = idx; end
             else if (k == 1) begin w[k] = 1'b1; w[8+6*k +: 6] = ~idx; end
           end
        5: w[8+6*k +: 6] = idx;
        default: ;
      endcase
    end
    return w;
  endfunction

  task automatic do_req(input logic [39:0] base, input logic [1:0] cls,
                        input logic [6:0] slot, input logic [5:0] idx,
                        input logic [2:0] alg, input int pat, input int hold);
    int          page, used, room, cnt, hit_k, t, rd0;
    logic [39:0] e_meta, e_addr;
    logic        e_cmp, e_err;
    logic [2:0]  e_alg;
    string       tag;
    logic [39:0] a0;

    page   = 512 * (1 << cls);                      // R2
    used   = 64 * int'(slot);
    e_err  = used > page;
    room   = page - used - 8;
    cnt    = (room < 0) ? 0 : room / 64;
    if (cnt > 8) cnt = 8;
    e_meta = base + 40'(used);
    tb_meta = mk_meta(pat, idx);
    hit_k = -1;
    for (int k = cnt - 1; k >= 0; k--)
      if (tb_meta[k] && tb_meta[8+6*k +: 6] == idx) hit_k = k;

    if (e_err) begin
      e_addr = '0; e_cmp = 0; e_alg = '0; tag = "R9";
    end else if (hit_k >= 0) begin
      e_addr = e_meta + 40'd8 + 40'(64 * hit_k); e_cmp = 0; e_alg = '0;
      tag = (pat == 2 || pat == 4) ? "R7" : "R6 R8";
    end else begin
      e_addr = base + 40'(idx) * 40'(slot); e_cmp = 1; e_alg = alg;
      tag = (cnt == 0) ? "R10" : "R3";
    end

    rd0 = rd_cnt;
    @(negedge clk);
    req_valid = 1; req_base = base; req_cls = cls; req_slot_b = slot;
    req_idx = idx; req_alg = alg;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R11", "ready after accept", 64'(req_ready), 0);
    t = 0;
    while (!resp_valid && t < 20) begin @(negedge clk); t++; end
    chk(resp_valid == 1, tag, "response arrives", 64'(resp_valid), 1);
    if (!e_err && hit_k < 0 && cnt == 0)
      chk(t == 0, "R10", "latency", 64'(t), 0);
    if (cnt > 0 && !e_err)
      chk(t == 2, "R4", "latency", 64'(t), 2);
    chk(resp_err == e_err, "R2", "error flag", 64'(resp_err), 64'(e_err));
    chk(resp_addr == e_addr, tag, "address", 64'(resp_addr), 64'(e_addr));
    chk(resp_compressed == e_cmp, tag, "compressed", 64'(resp_compressed), 64'(e_cmp));
    chk(resp_alg == e_alg, tag, "alg", 64'(resp_alg), 64'(e_alg));
    a0 = resp_addr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(resp_valid && resp_addr == a0 && !req_ready, "R11", "held response",
          64'(resp_addr), 64'(a0));
    end
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
    chk(!resp_valid && req_ready, "R11", "idle after handshake",
        64'({resp_valid, req_ready}), 64'b01);
    chk(rd_cnt - rd0 == ((cnt > 0 && !e_err) ? 1 : 0), (cnt > 0) ? "R5" : "R9 R10",
        "metadata reads", 64'(rd_cnt - rd0), 64'((cnt > 0 && !e_err) ? 1 : 0));
    if (cnt > 0 && !e_err)
      chk(rd_addr == e_meta, "R4", "metadata address", 64'(rd_addr), 64'(e_meta));
  endtask

  initial begin
    int slots [16] = '{0, 1, 7, 8, 9, 15, 16, 24, 31, 32, 48, 56, 63, 64, 65, 127};
    logic [5:0] idxs [4] = '{6'd0, 6'd1, 6'd17, 6'd63};
    int n = 0;
    logic [39:0] base;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && resp_valid == 0 && meta_rd_en == 0, "R1", "reset state",
        64'({req_ready, resp_valid, meta_rd_en}), 64'b100);
    @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 16; s++)
        for (int i = 0; i < 4; i++)
          for (int p = 0; p < 6; p++) begin
            base = (n % 97 == 0) ? 40'hFF_FFFF_FE00 : 40'h00_1234_5000 + 40'(n) * 40'h11_0000;
            do_req(base, 2'(c), 7'(slots[s]), idxs[i], 3'((n % 7) + 1), p, n % 5);
            n++;
          end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule